// File: doc/BRIEF.md
# Dual-Bank Packed Neuron-State Store

This block holds neuron state values, each three bits wide, in two equal banks. One bank belongs to the host port and the other to the compute port at any moment. The host fills one bank with the next input image while the compute engine works on the other. A host command then exchanges the two roles. The command waits until the compute side reports that it is idle.

The two sides see the same storage in different shapes. The compute port sees a memory one state wide, addressed by state index. Reads return data one cycle after the address, and a write changes only the addressed state. The host reaches the block through four 32-bit registers: control/status, pointer, data window and start. Each access to the data window moves eight states as one packed word and then advances the pointer by eight. Inside the block each bank is an array of rows, each row holding four states. The parameters default to a small depth; the full-size store is 16384 rows per bank (65536 states), set with `ROW_AW = 14`.

Top module: `pp_state_store`

## Requirements
- R1: After reset the host owns bank 0, no swap is pending, the pointer is 0, `host_rvalid`, `seq_start` and `cmp_rdata` are all 0.
- R2: A host write to register 2 stores bits [3k+2:3k] of the word into state index pointer+k of the host-owned bank, for k = 0..7. Bits 31:24 are ignored.
- R3: A host read (`host_sel`=1, `host_we`=0) raises `host_rvalid` in the next cycle with the register value on `host_rdata`. A read of register 2 returns state pointer+k in bits [3k+2:3k] and zero in bits 31:24.
- R4: Every host access to register 2 advances the pointer by 8, wrapping modulo the bank depth in states. A write to register 1 loads the pointer with the low three bits cleared. A read of register 1 returns the pointer.
- R5: `cmp_rdata` shows, one cycle after `cmp_addr`, the state held at that index in the compute-owned bank. The value is taken before any compute write in the same cycle.
- R6: A compute write (`cmp_we`) changes only the addressed state. The other three states of its row keep their values.
- R7: A host write to register 0 with bit 0 set requests a swap. The swap is applied at the first clock edge, the request edge included, at which `cmp_busy` is low. Until then the request stays pending. A write to register 0 with bit 0 clear has no effect on ownership.
- R8: Register 0 reads as: bit 0 = index of the host-owned bank, bit 1 = swap pending, bit 2 = current `cmp_busy`, other bits zero.
- R9: Host traffic never alters the compute-owned bank, and compute writes never alter the host-owned bank.
- R10: A host write to register 3 produces a one-cycle `seq_start` pulse in the following cycle.
- R11: Register 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host register access this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register index: 0 control/status, 1 pointer, 2 data, 3 start |
| host_wdata | input | HOST_DW (32) | Host write data |
| host_rdata | output | HOST_DW (32) | Host read data, valid with `host_rvalid` |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| cmp_busy | input | 1 | Compute side active; holds back bank swaps |
| cmp_we | input | 1 | Compute write of one state |
| cmp_addr | input | ROW_AW+2 (8) | Compute state index |
| cmp_wdata | input | STATE_W (3) | Compute write state |
| cmp_rdata | output | STATE_W (3) | State at the previous cycle's `cmp_addr` |
| seq_start | output | 1 | One-cycle start pulse for the compute sequencer |

## Verification
The hardest case to reach is a swap request that waits out a long busy period. It must not take effect while `cmp_busy` is high, it must remain visible as pending, and it must land at the exact edge where busy drops. The stimulus holds `cmp_busy` high across several cycles, polls the status register while the request waits, and then releases busy. The reference model predicts the edge at which the ownership bit flips. A second hard case is showing that a compute write leaves its three row neighbours alone. That can only be seen from the host side once the bank has been swapped back. So the stimulus fills a bank through the host, writes scattered states through the compute port, swaps, and reads the packed words back.

// File: rtl/pp_state_pkg.sv
package pp_state_pkg;

   // host register indices; the index decode is part of the port contract
   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_PTR   = 2'd1,
      REG_DATA  = 2'd2,
      REG_START = 2'd3
   } pp_reg_e;

   // control / status bit positions inside register 0
   localparam int unsigned CTRL_SWAP_BIT = 0;
   localparam int unsigned STAT_BANK_BIT = 0;
   localparam int unsigned STAT_PEND_BIT = 1;
   localparam int unsigned STAT_BUSY_BIT = 2;

endpackage

// File: rtl/pp_word_codec.sv
module pp_word_codec #(
   parameter int unsigned STATE_W     = 3,
   parameter int unsigned SLOTS       = 4,
   parameter int unsigned WORD_STATES = 8,
   parameter int unsigned HOST_DW     = 32
) (
   input  logic [HOST_DW-1:0]                          wr_word,
   output logic [STATE_W*WORD_STATES-1:0]              wr_rows,
   input  logic [STATE_W*WORD_STATES-1:0]              rd_rows,
   output logic [HOST_DW-1:0]                          rd_word
);
   localparam int unsigned ROW_W = STATE_W * SLOTS;
   localparam int unsigned RPW   = WORD_STATES / SLOTS;
   localparam int unsigned PAY_W = ROW_W * RPW;

   initial begin
      assert (WORD_STATES % SLOTS == 0) else $fatal(1, "word must hold whole rows");
      assert (PAY_W <= HOST_DW) else $fatal(1, "packed states exceed host word");
   end

   // row r of the pair carries word states r*SLOTS .. r*SLOTS+SLOTS-1
   for (genvar r = 0; r < RPW; r++) begin : g_row
      assign wr_rows[r*ROW_W +: ROW_W] = wr_word[r*ROW_W +: ROW_W];
   end

   if (HOST_DW > PAY_W) begin : g_pad
      logic unused_hi_bits;
      assign unused_hi_bits = ^wr_word[HOST_DW-1:PAY_W];
      assign rd_word = {{(HOST_DW-PAY_W){1'b0}}, rd_rows};
   end else begin : g_nopad
      assign rd_word = rd_rows;
   end

endmodule

// File: rtl/pp_state_bank.sv
module pp_state_bank #(
   parameter int unsigned STATE_W = 3,
   parameter int unsigned SLOTS   = 4,
   parameter int unsigned ROW_AW  = 6,
   parameter int unsigned RPW     = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   // host side: a group of RPW consecutive rows
   input  logic                          h_we,
   input  logic [ROW_AW-1:0]             h_row,
   input  logic [STATE_W*SLOTS*RPW-1:0]  h_wrows,
   output logic [STATE_W*SLOTS*RPW-1:0]  h_rrows,
   // compute side: one state slot
   input  logic                          c_we,
   input  logic [ROW_AW-1:0]             c_row,
   input  logic [$clog2(SLOTS)-1:0]      c_slot,
   input  logic [STATE_W-1:0]            c_wdata,
   output logic [STATE_W*SLOTS-1:0]      c_rrow
);
   localparam int unsigned ROW_W = STATE_W * SLOTS;
   localparam int unsigned ROWS  = 1 << ROW_AW;

   logic [ROW_W-1:0] mem [ROWS];
   logic [ROW_W-1:0] c_mask;
   logic [ROW_W-1:0] c_merged;

   initial begin
      assert (SLOTS >= 2) else $fatal(1, "row must hold at least two states");
      assert (RPW >= 1 && RPW <= ROWS) else $fatal(1, "bad rows per host word");
   end

   for (genvar r = 0; r < RPW; r++) begin : g_hrd
      assign h_rrows[r*ROW_W +: ROW_W] = mem[h_row + ROW_AW'(r)];
   end

   assign c_rrow   = mem[c_row];
   assign c_mask   = ROW_W'({STATE_W{1'b1}}) << (int'(c_slot) * STATE_W);
   assign c_merged = (c_rrow & ~c_mask) |
                     ((ROW_W'(c_wdata) << (int'(c_slot) * STATE_W)) & c_mask);

   // ownership keeps h_we and c_we on different banks in any cycle
   always_ff @(posedge clk) begin
      if (h_we) begin
         for (int r = 0; r < RPW; r++) begin
            mem[h_row + ROW_AW'(r)] <= h_wrows[r*ROW_W +: ROW_W];
         end
      end
      if (c_we) begin
         mem[c_row] <= c_merged;
      end
   end

   AST_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      c_we && !h_we |=> ((mem[$past(c_row)] ^ $past(c_rrow)) & ~$past(c_mask)) == '0); // R6

endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic swap_req,
   input  logic cmp_busy,
   output logic host_bank,
   output logic pending
);
   logic want;

   assign want = swap_req | pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_bank <= 1'b0;
         pending   <= 1'b0;
      end else if (want && !cmp_busy) begin
         host_bank <= ~host_bank;
         pending   <= 1'b0;
      end else begin
         pending   <= want;
      end
   end

   AST_SWAP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(host_bank) |-> $past(!cmp_busy)); // R7

   AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !cmp_busy |=> !pending && (host_bank != $past(host_bank))); // R7

endmodule

// File: rtl/pp_state_store.sv
module pp_state_store
   import pp_state_pkg::*;
#(
   parameter int unsigned STATE_W     = 3,
   parameter int unsigned SLOTS       = 4,
   parameter int unsigned ROW_AW      = 6,
   parameter int unsigned WORD_STATES = 8,
   parameter int unsigned HOST_DW     = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              host_sel,
   input  logic                              host_we,
   input  logic [1:0]                        host_reg,
   input  logic [HOST_DW-1:0]                host_wdata,
   output logic [HOST_DW-1:0]                host_rdata,
   output logic                              host_rvalid,
   input  logic                              cmp_busy,
   input  logic                              cmp_we,
   input  logic [ROW_AW+$clog2(SLOTS)-1:0]   cmp_addr,
   input  logic [STATE_W-1:0]                cmp_wdata,
   output logic [STATE_W-1:0]                cmp_rdata,
   output logic                              seq_start
);
   localparam int unsigned NBANK   = 2;
   localparam int unsigned SLOT_AW = $clog2(SLOTS);
   localparam int unsigned ST_AW   = ROW_AW + SLOT_AW;
   localparam int unsigned WORD_SH = $clog2(WORD_STATES);
   localparam int unsigned ROW_W   = STATE_W * SLOTS;
   localparam int unsigned RPW     = WORD_STATES / SLOTS;
   localparam int unsigned PAY_W   = ROW_W * RPW;

   initial begin
      assert ((1 << WORD_SH) == WORD_STATES) else $fatal(1, "word states must be a power of two");
      assert ((1 << SLOT_AW) == SLOTS) else $fatal(1, "slots must be a power of two");
      assert (ST_AW <= HOST_DW && WORD_SH < ST_AW) else $fatal(1, "pointer width out of range");
   end

   pp_reg_e                 reg_idx;
   logic                    wr_any, rd_any, wr_data, acc_data, swap_req;
   logic                    host_bank, pending;
   logic [ST_AW-1:0]        ptr;
   logic [ROW_AW-1:0]       host_row, cmp_row;
   logic [SLOT_AW-1:0]      cmp_slot;
   logic [PAY_W-1:0]        wr_rows, host_rows;
   logic [ROW_W-1:0]        cmp_row_data;
   logic [HOST_DW-1:0]      packed_word, status, rd_val;
   logic [PAY_W-1:0]        bank_hrows [NBANK];
   logic [ROW_W-1:0]        bank_crow  [NBANK];
   logic [NBANK-1:0]        bank_hwe, bank_cwe;

   assign reg_idx  = pp_reg_e'(host_reg);
   assign wr_any   = host_sel && host_we;
   assign rd_any   = host_sel && !host_we;
   assign acc_data = host_sel && (reg_idx == REG_DATA);
   assign wr_data  = wr_any && (reg_idx == REG_DATA);
   assign swap_req = wr_any && (reg_idx == REG_CTRL) && host_wdata[CTRL_SWAP_BIT];

   assign host_row = ptr[ST_AW-1:SLOT_AW];
   assign cmp_row  = cmp_addr[ST_AW-1:SLOT_AW];
   assign cmp_slot = cmp_addr[SLOT_AW-1:0];

   pp_swap_ctrl u_swap (
      .clk       (clk),
      .rst_n     (rst_n),
      .swap_req  (swap_req),
      .cmp_busy  (cmp_busy),
      .host_bank (host_bank),
      .pending   (pending)
   );

   pp_word_codec #(
      .STATE_W     (STATE_W),
      .SLOTS       (SLOTS),
      .WORD_STATES (WORD_STATES),
      .HOST_DW     (HOST_DW)
   ) u_codec (
      .wr_word (host_wdata),
      .wr_rows (wr_rows),
      .rd_rows (host_rows),
      .rd_word (packed_word)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_hwe[b] = wr_data && (host_bank == b[0]);
      assign bank_cwe[b] = cmp_we  && (host_bank != b[0]);

      pp_state_bank #(
         .STATE_W (STATE_W),
         .SLOTS   (SLOTS),
         .ROW_AW  (ROW_AW),
         .RPW     (RPW)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .h_we    (bank_hwe[b]),
         .h_row   (host_row),
         .h_wrows (wr_rows),
         .h_rrows (bank_hrows[b]),
         .c_we    (bank_cwe[b]),
         .c_row   (cmp_row),
         .c_slot  (cmp_slot),
         .c_wdata (cmp_wdata),
         .c_rrow  (bank_crow[b])
      );

      AST_BANK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
         !(bank_hwe[b] && bank_cwe[b])); // R9
   end

   assign host_rows    = bank_hrows[host_bank];
   assign cmp_row_data = bank_crow[~host_bank];

   always_comb begin
      status                = '0;
      status[STAT_BANK_BIT] = host_bank;
      status[STAT_PEND_BIT] = pending;
      status[STAT_BUSY_BIT] = cmp_busy;
   end

   always_comb begin
      case (reg_idx)
         REG_CTRL: rd_val = status;
         REG_PTR:  rd_val = HOST_DW'(ptr);
         REG_DATA: rd_val = packed_word;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr         <= '0;
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
         seq_start   <= 1'b0;
         cmp_rdata   <= '0;
      end else begin
         if (wr_any && (reg_idx == REG_PTR)) begin
            ptr <= {host_wdata[ST_AW-1:WORD_SH], {WORD_SH{1'b0}}};
         end else if (acc_data) begin
            ptr <= ptr + ST_AW'(WORD_STATES);
         end
         host_rvalid <= rd_any;
         if (rd_any) begin
            host_rdata <= rd_val;
         end
         seq_start <= wr_any && (reg_idx == REG_START);
         cmp_rdata <= cmp_row_data[int'(cmp_slot)*STATE_W +: STATE_W];
      end
   end

   if (HOST_DW > PAY_W) begin : g_chk_hi
      AST_DATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         host_rvalid && $past(host_reg == REG_DATA) |-> host_rdata[HOST_DW-1:PAY_W] == '0); // R3
   end

endmodule

// File: tb/pp_state_store_tb.sv
module pp_state_store_tb_top;
   localparam int ROW_AW = 6;
   localparam int STATES = (1 << ROW_AW) * 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_sel = 1'b0, h_we = 1'b0;
   logic [1:0]  h_reg = 2'd0;
   logic [31:0] h_wdata = 32'd0;
   logic [31:0] host_rdata;
   logic        host_rvalid;
   logic        busy = 1'b0, c_we = 1'b0;
   logic [7:0]  c_addr = 8'd0;
   logic [2:0]  c_wd = 3'd0;
   logic [2:0]  cmp_rdata;
   logic        seq_start;

   int checks = 0, errors = 0;
   bit done = 0;
   string cur_tag = "R5";

   // reference model
   int mdl [2][STATES];
   bit known [2][STATES];
   int hb = 0, pend = 0, ptr = 0;

   always #5 clk = ~clk;

   pp_state_store #(.ROW_AW(ROW_AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_sel(h_sel), .host_we(h_we), .host_reg(h_reg), .host_wdata(h_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .cmp_busy(busy), .cmp_we(c_we), .cmp_addr(c_addr), .cmp_wdata(c_wd),
      .cmp_rdata(cmp_rdata), .seq_start(seq_start)
   );

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock: predict from pre-edge state, advance model, sample after edge
   task automatic cyc();
      int cb, ex_cmp, ex_rd, rd_ok, req;
      bit ex_rv, ex_st;
      string rtag;
      cb     = 1 - hb;
      ex_cmp = known[cb][c_addr] ? mdl[cb][c_addr] : -1;
      ex_rv  = h_sel && !h_we;
      ex_st  = h_sel && h_we && (h_reg == 2'd3);
      ex_rd  = 0; rd_ok = 1; rtag = "R3";
      if (ex_rv) begin
         case (h_reg)
            2'd0: begin ex_rd = hb | (pend << 1) | (int'(busy) << 2); rtag = "R8"; end
            2'd1: begin ex_rd = ptr; rtag = "R4"; end
            2'd2: begin
               for (int k = 0; k < 8; k++) begin
                  if (!known[hb][ptr+k]) rd_ok = 0;
                  ex_rd |= mdl[hb][ptr+k] << (3*k);
               end
               rtag = "R3";
               ptr = (ptr + 8) % STATES;
            end
            default: begin ex_rd = 0; rtag = "R11"; end
         endcase
      end
      if (h_sel && h_we) begin
         if (h_reg == 2'd1) ptr = int'(h_wdata) & (STATES - 1) & ~7;
         if (h_reg == 2'd2) begin
            for (int k = 0; k < 8; k++) begin
               mdl[hb][ptr+k] = int'((h_wdata >> (3*k)) & 32'd7);
               known[hb][ptr+k] = 1;
            end
            ptr = (ptr + 8) % STATES;
         end
      end
      if (c_we) begin
         mdl[cb][c_addr] = int'(c_wd);
         known[cb][c_addr] = 1;
      end
      req = ((h_sel && h_we && h_reg == 2'd0 && h_wdata[0]) || pend != 0) ? 1 : 0;
      if (req != 0 && !busy) begin hb = 1 - hb; pend = 0; end
      else pend = req;
      @(posedge clk);
      #1;
      if (ex_cmp >= 0) chk(int'(cmp_rdata) == ex_cmp, cur_tag, cmp_rdata, ex_cmp);
      chk(host_rvalid == ex_rv, "R3 valid", host_rvalid, ex_rv);
      if (ex_rv && host_rvalid && rd_ok) chk(host_rdata == 32'(ex_rd), rtag, host_rdata, ex_rd);
      chk(seq_start == ex_st, "R10", seq_start, ex_st);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         h_sel = 0; h_we = 0; c_we = 0;
         cyc();
      end
   endtask

   task automatic hwr(logic [1:0] r, logic [31:0] d);
      h_sel = 1; h_we = 1; h_reg = r; h_wdata = d; c_we = 0;
      cyc();
      h_sel = 0; h_we = 0;
   endtask

   task automatic hrd(logic [1:0] r);
      h_sel = 1; h_we = 0; h_reg = r; c_we = 0;
      cyc();
      h_sel = 0;
   endtask

   task automatic cwr(int a, int d);
      c_we = 1; c_addr = 8'(a); c_wd = 3'(d);
      cyc();
      c_we = 0;
   endtask

   task automatic crd(int a);
      c_we = 0; c_addr = 8'(a);
      cyc();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      foreach (known[b, i]) begin known[b][i] = 0; mdl[b][i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      chk(host_rvalid == 0, "R1 rvalid", host_rvalid, 0);
      chk(seq_start == 0, "R1 start", seq_start, 0);
      chk(cmp_rdata == 0, "R1 cmp_rdata", cmp_rdata, 0);
      hrd(2'd0);                    // R1 / R8: bank 0, nothing pending
      hrd(2'd1);                    // R1 / R4: pointer 0

      // R2: fill bank 0 through the host, top byte set to prove it is ignored
      hwr(2'd1, 32'd0);
      for (int w = 0; w < STATES/8; w++)
         hwr(2'd2, 32'hFF00_0000 | (32'(w) * 32'h0012_3457 + 32'h0005_A3C1));
      hrd(2'd1);                    // R4: wrapped back to 0
      // R3: read back several words
      hwr(2'd1, 32'd40);
      for (int w = 0; w < 4; w++) hrd(2'd2);
      hrd(2'd1);                    // R4: 40 + 32
      hwr(2'd1, 32'd13);            // R4: low bits cleared -> 8
      hrd(2'd1);
      hrd(2'd2);

      // R7: plain swap while idle; control write with bit 0 clear does nothing
      hwr(2'd0, 32'd0);
      hrd(2'd0);
      hwr(2'd0, 32'd1);
      hrd(2'd0);                    // R8: host bank now 1

      // R5: compute side reads bank 0
      cur_tag = "R5";
      for (int a = 0; a < STATES; a += 5) crd(a);

      // R9: host fills bank 1 while compute reads bank 0
      cur_tag = "R9";
      hwr(2'd1, 32'd0);
      for (int w = 0; w < STATES/8; w++) begin
         c_addr = 8'(w * 7);
         hwr(2'd2, 32'(w) * 32'h0031_4159 + 32'h0026_5358);
      end
      for (int a = 0; a < STATES; a += 7) crd(a);

      // R6: compute writes single slots, neighbours checked from compute side
      cur_tag = "R6";
      cwr(9, 5); cwr(14, 2); cwr(19, 7); cwr(100, 0);
      for (int a = 8; a < 24; a++) crd(a);
      crd(100); crd(101); crd(99);
      // same-cycle write/read returns pre-write value (R5)
      cur_tag = "R5";
      c_we = 1; c_addr = 8'd30; c_wd = 3'd6; cyc(); c_we = 0;
      crd(30);

      // R7: swap held while busy
      cur_tag = "R7";
      busy = 1;
      hwr(2'd0, 32'd1);
      hrd(2'd0);                    // R8: pending, still bank 1, busy shown
      idle(3);
      hrd(2'd0);
      busy = 0;
      idle(1);                      // swap lands here
      hrd(2'd0);                    // R8: bank 0, not pending
      // R6: host reads packed words around the compute-written slots
      hwr(2'd1, 32'd8);
      hrd(2'd2); hrd(2'd2);
      hwr(2'd1, 32'd96);
      hrd(2'd2);

      // R10 / R11: start pulse and start register reads zero
      hwr(2'd3, 32'hFFFF_FFFF);
      idle(2);
      hrd(2'd3);

      // swap back and forth again to check the alternate pattern (R5, R7)
      hwr(2'd0, 32'd1);
      cur_tag = "R5";
      for (int a = 0; a < STATES; a += 11) crd(a);
      idle(2);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule